// File: doc/BRIEF.md
# PHY Link and Duplex Resolver

This block runs one link check against an external transceiver through a management-bus master. On a start pulse it asks the master for two register reads from the configured PHY address: the basic status register (1) and then the link-partner ability register (5). It uses the two values to decide whether the transceiver is absent, whether the link is down, or what operating mode the MAC should use.

When the link is up, the block ANDs the partner abilities with a local advertisement value to get the negotiated set. From that set it derives a full-duplex bit and a transmit-threshold bit inside a MAC mode word. All other bits of the mode word keep their value. If the word changes, the block stores the new value and asks for a transmit/receive restart. Every check ends with a one-cycle done pulse that carries a two-bit result code.

The status register latches its link bit low. For that reason a clear link bit on the first read triggers a second status read. The link is declared down only if that second read also shows the bit clear.

Top module: `phy_mode_resolver`

## Requirements
- R1: After reset, `mode_word` equals the parameter `MODE_RST` (default 0x020E0000), and `done`, `restart` and `rd_req` are low.
- R2: A start pulse while idle makes the block latch `phy_addr` and request a read of register 1, then a read of register 5, with `rd_phy` set to the latched address. Each request holds `rd_req`, `rd_reg` and `rd_phy` steady until the cycle in which `rd_ack` is high. `rd_data` is taken in that same cycle.
- R3: If the first status value is 0xFFFF, the check ends with code 3 (missing) after exactly two reads. The mode word does not change and no restart pulse is produced.
- R4: If bit 2 of the first status value is clear, register 1 is read a third time. If bit 2 is still clear, the check ends with code 2 (no link), and the mode word and restart stay as they were.
- R5: If bit 2 is clear on the first status read but set on the reread, the check goes on to the mode update.
- R6: The negotiated set is the partner value ANDed with `local_adv`. Abilities that only one side offers have no effect.
- R7: The transmit-threshold bit (bit `THR_BIT`, default 22) is cleared when the negotiated set has any of bits 7, 8 or 9 set (the 100 Mb/s abilities). Otherwise it is set.
- R8: The full-duplex bit (bit `FDX_BIT`, default 9) is set when any of these holds: `duplex_lock` is high; the negotiated set has bit 8; or the negotiated set has bit 6 with bit 7 clear. Otherwise it is cleared.
- R9: When the new mode word differs from the stored one, it is stored, the result code is 1 (changed), and `restart` pulses for one cycle together with `done`. Otherwise the result code is 0 (unchanged), no restart is produced, and the word stays the same. Bits other than the two mode bits are never altered.
- R10: `done` is a single-cycle pulse. `status` is valid in the cycle `done` is high, and `mode_word` already shows the new value in that cycle.
- R11: A start pulse while a check is in progress is ignored: it causes no extra reads and no extra done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin one link check |
| phy_addr | input | PHY_AW | PHY address to poll, latched at start |
| local_adv | input | DATA_W | Local advertisement value |
| duplex_lock | input | 1 | Force full duplex |
| rd_req | output | 1 | Read request to the management master |
| rd_phy | output | PHY_AW | PHY address of the request |
| rd_reg | output | REG_AW | Register address of the request |
| rd_ack | input | 1 | Read completed; rd_data is valid |
| rd_data | input | DATA_W | Read value |
| mode_word | output | MODE_W | MAC mode word |
| restart | output | 1 | Transmit/receive restart pulse |
| done | output | 1 | Check finished pulse |
| status | output | 2 | Result code: 0 unchanged, 1 changed, 2 no link, 3 missing |

## Verification
The hardest path to reach from the ports is the latched-low link bit: a first status read with bit 2 clear followed by a reread that returns bit 2 set. The bench's management responder serves successive register-1 reads from separate entries of each vector, so the two values can differ. Both outcomes of the reread are covered, and the number of reads is counted each time. A start pulse during a slow transaction is produced by stretching the responder latency and pulsing start partway through the check.

// File: rtl/phy_res_pkg.sv
// Package: shared result codes, sequencer states and register numbers
// for the PHY link and duplex resolver.
package phy_res_pkg;

    // Result code carried with the done pulse.
    typedef enum logic [1:0] {
        RES_UNCHANGED = 2'd0,
        RES_CHANGED   = 2'd1,
        RES_NOLINK    = 2'd2,
        RES_MISSING   = 2'd3
    } res_code_e;

    // How a check ended, as seen by the sequencer.
    typedef enum logic [1:0] {
        FIN_APPLY   = 2'd0,
        FIN_NOLINK  = 2'd1,
        FIN_MISSING = 2'd2
    } fin_kind_e;

    // Sequencer states.
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_STAT  = 3'd1,
        ST_PART  = 3'd2,
        ST_EVAL  = 3'd3,
        ST_STAT2 = 3'd4,
        ST_APPLY = 3'd5
    } seq_st_e;

    // Register numbers and bit positions in the management register set.
    localparam int unsigned REG_STATUS   = 1;
    localparam int unsigned REG_PARTNER  = 5;
    localparam int unsigned LINK_BIT     = 2;
    localparam int unsigned AB_10FD_BIT  = 6;
    localparam int unsigned AB_100HD_BIT = 7;
    localparam int unsigned AB_100FD_BIT = 8;
    localparam int unsigned AB_100T4_BIT = 9;

endpackage

// File: rtl/prs_seq.sv
// Module: prs_seq
// Issues the register reads of one link check and classifies the result.
// Assumes: the management master holds rd_data valid in the cycle rd_ack
// is high, and acknowledges only while rd_req is asserted.
module prs_seq
    import phy_res_pkg::*;
#(
    parameter int PHY_AW = 5,
    parameter int REG_AW = 5,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [PHY_AW-1:0] phy_addr,
    input  logic              rd_ack,
    input  logic [DATA_W-1:0] rd_data,
    output logic              rd_req,
    output logic [PHY_AW-1:0] rd_phy,
    output logic [REG_AW-1:0] rd_reg,
    output logic [DATA_W-1:0] part_val,
    output logic              fin_valid,
    output fin_kind_e         fin_kind
);

    localparam logic [DATA_W-1:0] ALL_ONES = {DATA_W{1'b1}};

    seq_st_e           state_q, state_d;
    logic [DATA_W-1:0] stat_q;
    logic [DATA_W-1:0] part_q;
    logic [PHY_AW-1:0] phy_q;

    // Next-state logic and end-of-check classification.
    always_comb begin
        state_d   = state_q;
        fin_valid = 1'b0;
        fin_kind  = FIN_APPLY;
        unique case (state_q)
            ST_IDLE:  if (start) state_d = ST_STAT;
            ST_STAT:  if (rd_ack) state_d = ST_PART;
            ST_PART:  if (rd_ack) state_d = ST_EVAL;
            ST_EVAL: begin
                if (stat_q == ALL_ONES) begin
                    state_d   = ST_IDLE;
                    fin_valid = 1'b1;
                    fin_kind  = FIN_MISSING;
                end else if (!stat_q[LINK_BIT]) begin
                    state_d = ST_STAT2;
                end else begin
                    state_d = ST_APPLY;
                end
            end
            ST_STAT2: begin
                if (rd_ack) begin
                    if (rd_data[LINK_BIT]) begin
                        state_d = ST_APPLY;
                    end else begin
                        state_d   = ST_IDLE;
                        fin_valid = 1'b1;
                        fin_kind  = FIN_NOLINK;
                    end
                end
            end
            ST_APPLY: begin
                state_d   = ST_IDLE;
                fin_valid = 1'b1;
                fin_kind  = FIN_APPLY;
            end
            default:  state_d = ST_IDLE;
        endcase
    end

    // State register, address latch and capture of read data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            stat_q  <= '0;
            part_q  <= '0;
            phy_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && start) phy_q <= phy_addr;
            if (state_q == ST_STAT && rd_ack) stat_q <= rd_data;
            if (state_q == ST_PART && rd_ack) part_q <= rd_data;
        end
    end

    // Request outputs follow the read states.
    always_comb begin
        rd_req = (state_q == ST_STAT) || (state_q == ST_PART) || (state_q == ST_STAT2);
        rd_reg = (state_q == ST_PART) ? REG_AW'(REG_PARTNER) : REG_AW'(REG_STATUS);
        rd_phy = phy_q;
    end

    assign part_val = part_q;

endmodule

// File: rtl/prs_calc.sv
// Module: prs_calc
// Combinational derivation of the next mode word from partner and local
// abilities. Assumes FDX_BIT and THR_BIT are distinct and below MODE_W.
module prs_calc
    import phy_res_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter int MODE_W  = 32,
    parameter int FDX_BIT = 9,
    parameter int THR_BIT = 22
) (
    input  logic [DATA_W-1:0] part_val,
    input  logic [DATA_W-1:0] local_adv,
    input  logic              duplex_lock,
    input  logic [MODE_W-1:0] mode_cur,
    output logic [MODE_W-1:0] mode_next,
    output logic              mode_diff
);

    logic [DATA_W-1:0] negot;
    logic              has_100;
    logic              fdx;

    // Negotiated set, speed class and duplex decision.
    always_comb begin
        negot   = part_val & local_adv;
        has_100 = negot[AB_100HD_BIT] | negot[AB_100FD_BIT] | negot[AB_100T4_BIT];
        fdx     = duplex_lock | negot[AB_100FD_BIT]
                | (negot[AB_10FD_BIT] & ~negot[AB_100HD_BIT]);
    end

    // Mode word with the two controlled bits replaced.
    always_comb begin
        mode_next          = mode_cur;
        mode_next[FDX_BIT] = fdx;
        mode_next[THR_BIT] = ~has_100;
        mode_diff          = (mode_next != mode_cur);
    end

endmodule

// File: rtl/prs_out.sv
// Module: prs_out
// Holds the mode word and produces done, status and restart.
// Assumes fin_valid is a single-cycle pulse from the sequencer.
module prs_out
    import phy_res_pkg::*;
#(
    parameter int               MODE_W   = 32,
    parameter logic [MODE_W-1:0] MODE_RST = 32'h020E_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fin_valid,
    input  fin_kind_e         fin_kind,
    input  logic [MODE_W-1:0] mode_next,
    input  logic              mode_diff,
    output logic [MODE_W-1:0] mode_q,
    output logic              done_q,
    output logic              restart_q,
    output res_code_e         status_q
);

    // Result registers; the mode word only moves on an applied change.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q    <= MODE_RST;
            done_q    <= 1'b0;
            restart_q <= 1'b0;
            status_q  <= RES_UNCHANGED;
        end else begin
            done_q    <= fin_valid;
            restart_q <= 1'b0;
            if (fin_valid) begin
                unique case (fin_kind)
                    FIN_MISSING: status_q <= RES_MISSING;
                    FIN_NOLINK:  status_q <= RES_NOLINK;
                    default: begin
                        if (mode_diff) begin
                            mode_q    <= mode_next;
                            restart_q <= 1'b1;
                            status_q  <= RES_CHANGED;
                        end else begin
                            status_q  <= RES_UNCHANGED;
                        end
                    end
                endcase
            end
        end
    end

endmodule

// File: rtl/phy_mode_resolver.sv
// Module: phy_mode_resolver
// Top level: polls one PHY through a management read port and keeps the
// MAC mode word in line with the negotiated link. Assumes one outstanding
// read at a time and a master that answers every request.
module phy_mode_resolver
    import phy_res_pkg::*;
#(
    parameter int               PHY_AW   = 5,
    parameter int               REG_AW   = 5,
    parameter int               DATA_W   = 16,
    parameter int               MODE_W   = 32,
    parameter int               FDX_BIT  = 9,
    parameter int               THR_BIT  = 22,
    parameter logic [MODE_W-1:0] MODE_RST = 32'h020E_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [PHY_AW-1:0] phy_addr,
    input  logic [DATA_W-1:0] local_adv,
    input  logic              duplex_lock,
    output logic              rd_req,
    output logic [PHY_AW-1:0] rd_phy,
    output logic [REG_AW-1:0] rd_reg,
    input  logic              rd_ack,
    input  logic [DATA_W-1:0] rd_data,
    output logic [MODE_W-1:0] mode_word,
    output logic              restart,
    output logic              done,
    output logic [1:0]        status
);

    logic [DATA_W-1:0] part_val;
    logic              fin_valid;
    fin_kind_e         fin_kind;
    logic [MODE_W-1:0] mode_next;
    logic              mode_diff;
    res_code_e         status_q;

    prs_seq #(
        .PHY_AW (PHY_AW),
        .REG_AW (REG_AW),
        .DATA_W (DATA_W)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .phy_addr  (phy_addr),
        .rd_ack    (rd_ack),
        .rd_data   (rd_data),
        .rd_req    (rd_req),
        .rd_phy    (rd_phy),
        .rd_reg    (rd_reg),
        .part_val  (part_val),
        .fin_valid (fin_valid),
        .fin_kind  (fin_kind)
    );

    prs_calc #(
        .DATA_W  (DATA_W),
        .MODE_W  (MODE_W),
        .FDX_BIT (FDX_BIT),
        .THR_BIT (THR_BIT)
    ) u_calc (
        .part_val    (part_val),
        .local_adv   (local_adv),
        .duplex_lock (duplex_lock),
        .mode_cur    (mode_word),
        .mode_next   (mode_next),
        .mode_diff   (mode_diff)
    );

    prs_out #(
        .MODE_W   (MODE_W),
        .MODE_RST (MODE_RST)
    ) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .fin_valid (fin_valid),
        .fin_kind  (fin_kind),
        .mode_next (mode_next),
        .mode_diff (mode_diff),
        .mode_q    (mode_word),
        .done_q    (done),
        .restart_q (restart),
        .status_q  (status_q)
    );

    assign status = status_q;

endmodule

// File: rtl/phy_mode_resolver_chk.sv
// Module: phy_mode_resolver_chk
// Protocol and result checks on the resolver's ports, bound to the top.
module phy_mode_resolver_chk #(
    parameter int PHY_AW = 5,
    parameter int REG_AW = 5,
    parameter int MODE_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd_req,
    input logic              rd_ack,
    input logic [PHY_AW-1:0] rd_phy,
    input logic [REG_AW-1:0] rd_reg,
    input logic [MODE_W-1:0] mode_word,
    input logic              restart,
    input logic              done,
    input logic [1:0]        status
);

    // R2
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !rd_ack) |=> (rd_req && $stable(rd_reg) && $stable(rd_phy)));

    // R2
    req_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |-> (rd_reg == REG_AW'(1) || rd_reg == REG_AW'(5)));

    // R3
    missing_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && status == 2'd3) |-> ($stable(mode_word) && !restart));

    // R4
    nolink_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && status == 2'd2) |-> ($stable(mode_word) && !restart));

    // R9
    restart_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart |-> (done && status == 2'd1));

    // R9
    unchanged_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && status == 2'd0) |-> ($stable(mode_word) && !restart));

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10
    mode_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mode_word) |-> done);

endmodule

bind phy_mode_resolver phy_mode_resolver_chk #(
    .PHY_AW (PHY_AW),
    .REG_AW (REG_AW),
    .MODE_W (MODE_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_req    (rd_req),
    .rd_ack    (rd_ack),
    .rd_phy    (rd_phy),
    .rd_reg    (rd_reg),
    .mode_word (mode_word),
    .restart   (restart),
    .done      (done),
    .status    (status)
);

// File: tb/phy_mode_resolver_tb.sv
module phy_mode_resolver_tb;

    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] MODE_RST = 32'h020E_0000;
    localparam int FDX = 9;
    localparam int THR = 22;
    localparam int NVEC = 11;

    typedef struct packed {
        logic [15:0] stat1;
        logic [15:0] part;
        logic [15:0] stat2;
        logic [15:0] adv;
        logic        lock;
        logic [1:0]  code;
        logic [3:0]  reads;
    } vec_t;

    // stimulus and expected code / read count, walked in order
    localparam vec_t VECS [NVEC] = '{
        '{16'h782D, 16'h41E1, 16'h0000, 16'h01E1, 1'b0, 2'd1, 4'd2}, // 100FD -> fdx, no thr
        '{16'h782D, 16'h41E1, 16'h0000, 16'h01E1, 1'b0, 2'd0, 4'd2}, // repeat: unchanged
        '{16'h782D, 16'h0021, 16'h0000, 16'h01E1, 1'b0, 2'd1, 4'd2}, // 10HD -> thr, half
        '{16'hFFFF, 16'h01E1, 16'h0000, 16'h01E1, 1'b0, 2'd3, 4'd2}, // missing
        '{16'h7809, 16'h01E1, 16'h7809, 16'h01E1, 1'b0, 2'd2, 4'd3}, // no link twice
        '{16'h7809, 16'h0041, 16'h782D, 16'h01E1, 1'b0, 2'd1, 4'd3}, // latched low, then up; 10FD
        '{16'h782D, 16'h00C1, 16'h0000, 16'h01E1, 1'b0, 2'd1, 4'd2}, // 100HD+10FD -> half
        '{16'h782D, 16'h0081, 16'h0000, 16'h01E1, 1'b1, 2'd1, 4'd2}, // lock forces full
        '{16'h782D, 16'h01E1, 16'h0000, 16'h0021, 1'b0, 2'd1, 4'd2}, // adv masks 100
        '{16'h782D, 16'h0200, 16'h0000, 16'h03E1, 1'b0, 2'd1, 4'd2}, // T4 only
        '{16'h782D, 16'h0200, 16'h0000, 16'h03E1, 1'b0, 2'd0, 4'd2}  // repeat: unchanged
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [4:0]  phy_addr = 5'd0;
    logic [15:0] local_adv = 16'h0;
    logic        duplex_lock = 1'b0;
    logic        rd_req;
    logic [4:0]  rd_phy;
    logic [4:0]  rd_reg;
    logic        rd_ack = 1'b0;
    logic [15:0] rd_data = 16'h0;
    logic [31:0] mode_word;
    logic        restart;
    logic        done;
    logic [1:0]  status;

    int checks = 0;
    int errors = 0;

    // responder state
    logic [15:0] r_stat1, r_part, r_stat2;
    int          lat = 0;
    int          wait_cnt = 0;
    int          n_reads = 0;
    int          n_stat = 0;
    logic [4:0]  reg_log [4];
    logic        phy_bad = 1'b0;
    int          done_cnt = 0;
    logic [31:0] exp_mode = MODE_RST;

    always #(CLK_PERIOD/2) clk = ~clk;

    phy_mode_resolver u_dut (
        .clk (clk), .rst_n (rst_n), .start (start), .phy_addr (phy_addr),
        .local_adv (local_adv), .duplex_lock (duplex_lock),
        .rd_req (rd_req), .rd_phy (rd_phy), .rd_reg (rd_reg),
        .rd_ack (rd_ack), .rd_data (rd_data),
        .mode_word (mode_word), .restart (restart), .done (done), .status (status)
    );

    // management master model, acts on falling edges
    initial begin
        forever begin
            @(negedge clk);
            if (rd_ack) begin
                rd_ack = 1'b0;
            end else if (rd_req) begin
                if (wait_cnt >= lat) begin
                    wait_cnt = 0;
                    if (n_reads < 4) reg_log[n_reads] = rd_reg;
                    if (rd_phy != phy_addr) phy_bad = 1'b1;
                    n_reads++;
                    if (rd_reg == 5'd5) begin
                        rd_data = r_part;
                    end else begin
                        rd_data = (n_stat == 0) ? r_stat1 : r_stat2;
                        n_stat++;
                    end
                    rd_ack = 1'b1;
                end else begin
                    wait_cnt++;
                end
            end
        end
    end

    always @(posedge clk) if (rst_n && done) done_cnt <= done_cnt + 1;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] model(input logic [31:0] old, input logic [15:0] part,
                                          input logic [15:0] adv, input logic lock);
        logic [15:0] n;
        logic [31:0] m;
        n = part & adv;
        m = old;
        m[THR] = !(n[7] || n[8] || n[9]);
        m[FDX] = lock || n[8] || (n[6] && !n[7]);
        return m;
    endfunction

    task automatic prime(input logic [15:0] s1, input logic [15:0] p, input logic [15:0] s2);
        r_stat1 = s1; r_part = p; r_stat2 = s2;
        n_reads = 0; n_stat = 0; wait_cnt = 0; phy_bad = 1'b0;
    endtask

    task automatic pulse_start();
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done(output bit seen);
        seen = 1'b0;
        for (int c = 0; c < 500; c++) begin
            if (done) begin seen = 1'b1; break; end
            @(negedge clk);
        end
    endtask

    // one check with expected result from a vector
    task automatic run_vec(input vec_t v, input int idx);
        bit seen;
        logic [31:0] m;
        prime(v.stat1, v.part, v.stat2);
        local_adv = v.adv;
        duplex_lock = v.lock;
        lat = idx % 3;
        pulse_start();
        wait_done(seen);
        check(seen, "R10", $sformatf("vec %0d done seen", idx), 32'(seen), 32'd1);
        if (v.code == 2'd0 || v.code == 2'd1) m = model(exp_mode, v.part, v.adv, v.lock);
        else m = exp_mode;
        check(status == v.code, (v.code == 3) ? "R3" : (v.code == 2) ? "R4" : "R9",
              $sformatf("vec %0d status", idx), 32'(status), 32'(v.code));
        check(mode_word == m, "R7/R8", $sformatf("vec %0d mode", idx), mode_word, m);
        check(restart == (v.code == 2'd1), "R9", $sformatf("vec %0d restart", idx),
              32'(restart), 32'(v.code == 2'd1));
        check(n_reads == int'(v.reads), (v.reads == 3) ? "R4/R5" : "R3/R2",
              $sformatf("vec %0d read count", idx), 32'(n_reads), 32'(v.reads));
        check(reg_log[0] == 5'd1 && reg_log[1] == 5'd5, "R2",
              $sformatf("vec %0d read order", idx), {reg_log[0], reg_log[1]}, {5'd1, 5'd5});
        if (v.reads == 3)
            check(reg_log[2] == 5'd1, "R4", $sformatf("vec %0d reread reg", idx),
                  32'(reg_log[2]), 32'd1);
        check(!phy_bad, "R2", $sformatf("vec %0d phy address", idx), 32'(phy_bad), 32'd0);
        exp_mode = m;
        @(negedge clk);
        check(!done && !restart, "R10", $sformatf("vec %0d pulse width", idx),
              {30'd0, done, restart}, 32'd0);
    endtask

    initial begin
        bit seen;
        int d0;
        for (int k = 0; k < 4; k++) reg_log[k] = 5'd0;
        phy_addr = 5'd17;
        repeat (5) @(negedge clk);
        // R1 reset state (reset still applied)
        check(mode_word == MODE_RST, "R1", "reset mode", mode_word, MODE_RST);
        check(!done && !restart && !rd_req, "R1", "reset controls",
              {29'd0, done, restart, rd_req}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!rd_req && !done, "R1", "idle after reset", {30'd0, rd_req, done}, 32'd0);

        for (int i = 0; i < NVEC; i++) begin
            if (i == 6) phy_addr = 5'd3;
            run_vec(VECS[i], i);
        end

        // R11: start during a slow check is ignored
        prime(16'h782D, 16'h0021, 16'h0000);
        local_adv = 16'h01E1; duplex_lock = 1'b0;
        lat = 6;
        d0 = done_cnt;
        pulse_start();
        repeat (3) @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done(seen);
        repeat (20) @(negedge clk);
        check(n_reads == 2, "R11", "reads with busy start", 32'(n_reads), 32'd2);
        check(done_cnt - d0 == 1, "R11", "done count with busy start",
              32'(done_cnt - d0), 32'd1);
        check(!rd_req, "R11", "no request after finish", 32'(rd_req), 32'd0);
        exp_mode = model(exp_mode, 16'h0021, 16'h01E1, 1'b0);
        check(mode_word == exp_mode, "R6", "mode after busy test", mode_word, exp_mode);

        // R1: reset returns the mode word to its reset value
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check(mode_word == MODE_RST, "R1", "mode after second reset", mode_word, MODE_RST);
        rst_n = 1'b1;
        @(negedge clk);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // watchdog
    initial begin
        #(CLK_PERIOD * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule